// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This unit sits on the processor side of a cache controller. It gives software an atomic read-then-write primitive built from two special accesses. A load-linked access reads one word from memory and records a reservation on that word. A later store-conditional to the same word writes to memory only if the reservation is still intact, and it answers the processor with 1 on success or 0 on failure, in the same way as a read.

The unit keeps exactly one reservation: a valid bit and a word index. It watches the write traffic of other bus masters through a snoop port. When another master writes any byte of the reserved word, the reservation is dropped. Requests go to memory through a simple request/grant port. The moment of grant is the bus order point, so when several processors race, the first store-conditional granted on the bus wins.

Ordinary loads and stores pass through the same port and do not create a reservation. A local ordinary store also does not cancel one. The unit handles one request at a time. Operation codes on `cpu_req_op` are: 00 load, 01 store, 10 load-linked, 11 store-conditional.

Top module: `llsc_reservation_unit`

## Requirements
- R1: After reset there is no reservation, `cpu_req_ready` is 1, and neither `mem_req_valid` nor `cpu_rsp_valid` is asserted. A store-conditional issued straight after reset returns 0 and causes no memory write.
- R2: A load-linked (op 10) reads the addressed word through the memory port and returns the read data. The reservation is recorded on the word index (address bits above the byte offset) when the read is granted.
- R3: A store-conditional (op 11) to the reserved word, with the reservation still valid, is issued as a memory write of its data and returns 1. The reservation is then cleared, so a repeated store-conditional returns 0.
- R4: A snooped write (`snp_valid` with `snp_addr`) to any byte of the reserved word cancels the reservation. A following store-conditional returns 0 and makes no memory write.
- R5: A snooped write to a different word leaves the reservation valid.
- R6: A store-conditional to a word other than the reserved one returns 0, makes no write and clears the reservation.
- R7: If a snooped write to the reserved word arrives in the cycle a pending store-conditional could be granted, the remote write is ordered first. The store-conditional withdraws its write and returns 0.
- R8: A new load-linked replaces any earlier reservation. Only the newest reserved word can then succeed.
- R9: An ordinary store (op 01) to the reserved word is written to memory, returns 0, and does not cancel the reservation.
- R10: An ordinary load (op 00) returns the memory word and creates no reservation.
- R11: `cpu_req_ready` is high only while idle. Each request gets exactly one single-cycle `cpu_rsp_valid` pulse, and no memory request is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request strobe |
| cpu_req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| cpu_req_addr | input | ADDR_W | Byte address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Unit idle, request accepted this cycle |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_data | output | DATA_W | Read data, or success flag for store-conditional |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_req_grant | input | 1 | Bus grant; the request takes effect in this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DATA_W | Read data |
| snp_valid | input | 1 | Another master writes on the bus this cycle |
| snp_addr | input | ADDR_W | Byte address of that write |

## Verification
A reservation that is wrongly set or wrongly kept shows up as a store-conditional that returns 1 and writes memory when it should not. A reservation that is lost when it should stay shows up as a 0 where a 1 is expected. Either error is visible at the next store-conditional response, a few cycles after the stimulus, together with a change in the memory write count. The same-cycle race is checked by holding the grant back and releasing it in the same cycle as a snooped write. In that case the write request must drop in that very cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } llsc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_SC_REQ,
    ST_RESP
  } llsc_state_e;

endpackage

// File: rtl/llsc_addr_match.sv
module llsc_addr_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              probe_en,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              resv_valid,
  input  logic [ADDR_W-1:0] resv_word,
  output logic              hit
);

  // word index of a byte address
  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a >> OFF_W;
  endfunction

  assign hit = probe_en && resv_valid && (word_of(probe_addr) == resv_word);

endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_word_i,
  input  logic              clr_i,
  input  logic              kill_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] word_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      word_o  <= set_word_i;
    end else if (clr_i || kill_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_RESV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (valid_o && word_o == $past(set_word_i))); // R2
  AST_RESV_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_i && !set_i) |=> !valid_o); // R4
  AST_RESV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !valid_o); // R6
  AST_RESV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !set_i && !clr_i && !kill_i) |=> (valid_o && $stable(word_o))); // R9

endmodule

// File: rtl/llsc_req_fsm.sv
module llsc_req_fsm
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_grant,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              cpu_match,
  input  logic              resv_live,
  output logic              resv_set,
  output logic [ADDR_W-1:0] resv_set_word,
  output logic              resv_clr,
  output logic              sc_pending,
  output logic              sc_win,
  output logic              rsp_is_sc
);

  llsc_state_e       state_q, state_d;
  llsc_op_e          op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_q;
  logic              accept;
  logic              sc_miss_now;
  logic              sc_lose;

  assign accept      = (state_q == ST_IDLE) && cpu_req_valid;
  assign sc_miss_now = accept && (llsc_op_e'(cpu_req_op) == OP_SC) && !cpu_match;
  assign sc_pending  = (state_q == ST_SC_REQ);
  assign sc_win      = sc_pending && resv_live && mem_req_grant;
  assign sc_lose     = sc_pending && !resv_live;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cpu_req_valid) begin
        unique case (llsc_op_e'(cpu_req_op))
          OP_LOAD, OP_LL: state_d = ST_RD_REQ;
          OP_STORE:       state_d = ST_WR_REQ;
          OP_SC:          state_d = cpu_match ? ST_SC_REQ : ST_RESP;
          default:        state_d = ST_IDLE;
        endcase
      end
      ST_RD_REQ:  if (mem_req_grant) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_WR_REQ:  if (mem_req_grant) state_d = ST_RESP;
      ST_SC_REQ:  if (!resv_live || mem_req_grant) state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q    <= llsc_op_e'(cpu_req_op);
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
      if (sc_miss_now || sc_lose || (state_q == ST_WR_REQ && mem_req_grant)) begin
        rsp_q <= '0;
      end else if (sc_win) begin
        rsp_q <= {{(DATA_W-1){1'b0}}, 1'b1};
      end else if (state_q == ST_RD_WAIT && mem_rsp_valid) begin
        rsp_q <= mem_rsp_rdata;
      end
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_data  = rsp_q;
  assign rsp_is_sc     = (op_q == OP_SC);

  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ) ||
                         (sc_pending && resv_live);
  assign mem_req_write = (state_q == ST_WR_REQ) || sc_pending;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  assign resv_set      = (state_q == ST_RD_REQ) && mem_req_grant && (op_q == OP_LL);
  assign resv_set_word = addr_q >> OFF_W;
  assign resv_clr      = sc_win || sc_miss_now;

  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !mem_req_valid); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> (!cpu_rsp_valid && cpu_req_ready)); // R11
  AST_LOAD_NO_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_LOAD) |-> !resv_set); // R10

endmodule

// File: rtl/llsc_reservation_unit.sv
module llsc_reservation_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_req_grant,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);

  localparam int OFF_W   = $clog2(DATA_W / 8);
  localparam int N_PROBE = 2;   // probe 0: snoop port, probe 1: processor port

  logic              resv_valid;
  logic [ADDR_W-1:0] resv_word;
  logic              resv_set;
  logic [ADDR_W-1:0] resv_set_word;
  logic              resv_clr;
  logic              snoop_kill;
  logic              cpu_match;
  logic              resv_live;
  logic              sc_pending;
  logic              sc_win;
  logic              rsp_is_sc;

  logic              probe_en   [N_PROBE];
  logic [ADDR_W-1:0] probe_addr [N_PROBE];
  logic              probe_hit  [N_PROBE];

  assign probe_en[0]   = snp_valid;
  assign probe_addr[0] = snp_addr;
  assign probe_en[1]   = 1'b1;
  assign probe_addr[1] = cpu_req_addr;

  for (genvar g = 0; g < N_PROBE; g++) begin : g_probe
    llsc_addr_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
      .probe_en   (probe_en[g]),
      .probe_addr (probe_addr[g]),
      .resv_valid (resv_valid),
      .resv_word  (resv_word),
      .hit        (probe_hit[g])
    );
  end

  assign snoop_kill = probe_hit[0];
  assign cpu_match  = probe_hit[1];
  // a remote write seen this cycle is ordered before any local grant
  assign resv_live  = resv_valid && !snoop_kill;

  llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (resv_set),
    .set_word_i (resv_set_word),
    .clr_i      (resv_clr),
    .kill_i     (snoop_kill),
    .valid_o    (resv_valid),
    .word_o     (resv_word)
  );

  llsc_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_op    (cpu_req_op),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_data  (cpu_rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_grant (mem_req_grant),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .cpu_match     (cpu_match),
    .resv_live     (resv_live),
    .resv_set      (resv_set),
    .resv_set_word (resv_set_word),
    .resv_clr      (resv_clr),
    .sc_pending    (sc_pending),
    .sc_win        (sc_win),
    .rsp_is_sc     (rsp_is_sc)
  );

  AST_SC_WIN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    sc_win |=> (cpu_rsp_valid && cpu_rsp_data == DATA_W'(1) && !resv_valid)); // R3
  AST_SC_RSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && rsp_is_sc) |-> (cpu_rsp_data[DATA_W-1:1] == '0)); // R3
  AST_RACE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_pending && snoop_kill) |-> !mem_req_valid); // R7
  AST_SC_WRITE_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_pending && mem_req_valid) |-> (resv_valid && (mem_req_addr >> OFF_W) == resv_word)); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(!rst_n) |-> (!resv_valid && cpu_req_ready && !cpu_rsp_valid)); // R1

endmodule

// File: tb/tb_llsc_reservation_unit.sv
module tb_llsc_reservation_unit;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic [1:0]    cpu_req_op = 2'b00;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_data;
  logic          mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_req_grant;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_rdata;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          hold_grant = 1'b0;

  logic [DW-1:0] mem [NW];
  int            wr_cnt;
  int            n_checks = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  llsc_reservation_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_data(cpu_rsp_data), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_grant(mem_req_grant),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  // memory model: grant at once unless held, read data one cycle after grant
  assign mem_req_grant = mem_req_valid && !hold_grant;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= 32'hA000_0000 + DW'(i);
      wr_cnt        <= 0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
    end else begin
      mem_rsp_valid <= mem_req_grant && !mem_req_write;
      mem_rsp_rdata <= mem[mem_req_addr[5:2]];
      if (mem_req_grant && mem_req_write) begin
        mem[mem_req_addr[5:2]] <= mem_req_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 load, 1 store, 2 LL, 3 SC; mode: 0 none, 1 snoop before, 2 snoop in grant cycle
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  mode;
    logic [7:0]  saddr;
    logic [31:0] exp;
    logic        exp_wr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h10, 32'h0,    2'd0, 8'h00, 32'hA000_0004, 1'b0, 4'd10}, // R10 load
    '{2'd3, 8'h10, 32'h11,   2'd0, 8'h00, 32'h0,         1'b0, 4'd10}, // R10 no reservation
    '{2'd2, 8'h10, 32'h0,    2'd0, 8'h00, 32'hA000_0004, 1'b0, 4'd2},  // R2 LL
    '{2'd3, 8'h10, 32'h1111, 2'd0, 8'h00, 32'h1,         1'b1, 4'd3},  // R3 success
    '{2'd3, 8'h10, 32'h2222, 2'd0, 8'h00, 32'h0,         1'b0, 4'd3},  // R3 cleared
    '{2'd2, 8'h20, 32'h0,    2'd0, 8'h00, 32'hA000_0008, 1'b0, 4'd2},  // R2
    '{2'd3, 8'h20, 32'h77,   2'd1, 8'h23, 32'h0,         1'b0, 4'd4},  // R4 byte of word
    '{2'd2, 8'h20, 32'h0,    2'd0, 8'h00, 32'hA000_0008, 1'b0, 4'd2},  // R2
    '{2'd3, 8'h20, 32'h3333, 2'd1, 8'h24, 32'h1,         1'b1, 4'd5},  // R5 other word
    '{2'd2, 8'h08, 32'h0,    2'd0, 8'h00, 32'hA000_0002, 1'b0, 4'd2},  // R2
    '{2'd3, 8'h0C, 32'h44,   2'd0, 8'h00, 32'h0,         1'b0, 4'd6},  // R6 mismatch
    '{2'd3, 8'h08, 32'h45,   2'd0, 8'h00, 32'h0,         1'b0, 4'd6},  // R6 cleared
    '{2'd2, 8'h04, 32'h0,    2'd0, 8'h00, 32'hA000_0001, 1'b0, 4'd2},  // R2
    '{2'd2, 8'h30, 32'h0,    2'd0, 8'h00, 32'hA000_000C, 1'b0, 4'd8},  // R8 overwrite
    '{2'd3, 8'h04, 32'h46,   2'd0, 8'h00, 32'h0,         1'b0, 4'd8},  // R8 old word fails
    '{2'd2, 8'h30, 32'h0,    2'd0, 8'h00, 32'hA000_000C, 1'b0, 4'd8},  // R8
    '{2'd3, 8'h30, 32'h4444, 2'd0, 8'h00, 32'h1,         1'b1, 4'd8},  // R8 newest wins
    '{2'd2, 8'h18, 32'h0,    2'd0, 8'h00, 32'hA000_0006, 1'b0, 4'd2},  // R2
    '{2'd1, 8'h18, 32'h5555, 2'd0, 8'h00, 32'h0,         1'b1, 4'd9},  // R9 local store
    '{2'd3, 8'h18, 32'h6666, 2'd0, 8'h00, 32'h1,         1'b1, 4'd9},  // R9 still valid
    '{2'd2, 8'h28, 32'h0,    2'd0, 8'h00, 32'hA000_000A, 1'b0, 4'd2},  // R2
    '{2'd3, 8'h28, 32'h7777, 2'd2, 8'h28, 32'h0,         1'b0, 4'd7}   // R7 race lost
  };

  task automatic run_op(input vec_t v);
    int  base;
    bit  got;
    string tag;
    tag = $sformatf("R%0d", v.req);
    if (v.mode == 2'd1) begin
      @(negedge clk); snp_valid = 1'b1; snp_addr = AW'(v.saddr);
      @(negedge clk); snp_valid = 1'b0;
    end
    if (v.mode == 2'd2) hold_grant = 1'b1;
    @(negedge clk);
    base = wr_cnt;
    cpu_req_valid = 1'b1; cpu_req_op = v.op;
    cpu_req_addr = AW'(v.addr); cpu_req_wdata = v.wdata;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check(!cpu_req_ready, "R11 ready while busy", DW'(cpu_req_ready), 0);
    if (v.mode == 2'd2) begin
      for (int n = 0; n < 20; n++) begin
        if (mem_req_valid) break;
        @(negedge clk);
      end
      snp_valid = 1'b1; snp_addr = AW'(v.saddr); hold_grant = 1'b0;
      @(negedge clk);
      snp_valid = 1'b0;
    end
    got = 1'b0;
    for (int n = 0; n < 50; n++) begin
      if (cpu_rsp_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got && cpu_rsp_data == v.exp, tag, cpu_rsp_data, v.exp);
    check((wr_cnt - base) == int'(v.exp_wr), {tag, " write count"},
          DW'(wr_cnt - base), DW'(v.exp_wr));
    if (v.exp_wr)
      check(mem[v.addr[5:2]] == v.wdata, {tag, " memory word"}, mem[v.addr[5:2]], v.wdata);
    @(negedge clk);
    check(!cpu_rsp_valid && cpu_req_ready, "R11 single pulse", DW'(cpu_rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(cpu_req_ready && !mem_req_valid && !cpu_rsp_valid, "R1 idle after reset",
          {29'd0, cpu_req_ready, mem_req_valid, cpu_rsp_valid}, 32'h4);
    run_op('{2'd3, 8'h00, 32'h99, 2'd0, 8'h00, 32'h0, 1'b0, 4'd1}); // R1 no reservation
    for (int i = 0; i < NV; i++) run_op(VECS[i]);
    // R5 corner: snoop on the neighbouring word right before the winning SC
    run_op('{2'd2, 8'h3C, 32'h0,  2'd0, 8'h00, 32'hA000_000F, 1'b0, 4'd2});
    run_op('{2'd3, 8'h3C, 32'h88, 2'd1, 8'h38, 32'h1, 1'b1, 4'd5});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule